// File: doc/BRIEF.md
# Debug Exception Restart Address Capture

This block records where a processor core should restart after it enters its debug handler. It also records why the handler was entered. A capture happens whenever the core takes a debug exception, and also when it takes any exception while it is already running in debug mode. The core supplies three candidate addresses:

- the virtual address of the faulting instruction;
- the address of the branch or jump that precedes it;
- the address where execution continues once debug mode is left.

Two qualifiers pick one of the three: whether the exception is precise, and whether the faulting instruction sits in a branch delay slot.

Debug software reaches the captured state through a small coprocessor-style register port. Address 0 selects the 32-bit restart address register, which software can read and write in full. Address 1 selects a read-only status word. That word holds four one-hot cause flags and a branch-delay indicator. Captures take effect at the clock edge on which the exception is presented. Read data is combinational from the stored state, so a capture is visible on the read port in the cycle after that edge.

Top module: `dbg_epc_capture`

## Requirements
- R1: After reset the restart address register reads 0 and the status word reads 0.
- R2: A write with `regWrEn`=1 and `regAddr`=0, in a cycle without a capture, stores all 32 bits of `regWrData`. The new value reads back at address 0 in the next cycle.
- R3: On a capture with `excPrecise`=1 and `inDelaySlot`=0, the register takes `faultPc` and the branch-delay indicator clears.
- R4: On a capture with `excPrecise`=1 and `inDelaySlot`=1, the register takes `branchPc` and the branch-delay indicator sets.
- R5: On a capture with `excPrecise`=0, the register takes `resumePc` and the branch-delay indicator keeps its previous value.
- R6: On a capture with `inDebugMode`=0, the cause flags take the one-hot `causeStrobe`. Bit 3 is data break on store, bit 2 is data break on load, bit 1 is breakpoint and bit 0 is single step. Only the flag of the asserted strobe is 1.
- R7: On a capture with `inDebugMode`=1, all four cause flags clear, whatever `causeStrobe` holds.
- R8: Writes to address 1 change neither the status word nor the restart address.
- R9: If a software write to address 0 and a capture occur in the same cycle, the captured address is stored and the written data is lost.
- R10: The status word carries the branch-delay indicator at bit 31 and the cause flags at bits 3:0. Every other bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| excValid | input | 1 | An exception is taken this cycle and must be captured |
| inDebugMode | input | 1 | The core was already in debug mode when the exception was taken |
| excPrecise | input | 1 | 1 = precise exception, 0 = imprecise |
| inDelaySlot | input | 1 | The faulting instruction is in a branch delay slot |
| faultPc | input | 32 | Virtual address of the faulting instruction |
| branchPc | input | 32 | Address of the preceding branch or jump |
| resumePc | input | 32 | Address at which execution continues after debug mode |
| causeStrobe | input | 4 | One-hot cause: [3] store break, [2] load break, [1] breakpoint, [0] single step |
| regWrEn | input | 1 | Register port write enable |
| regAddr | input | 1 | 0 = restart address, 1 = status word |
| regWrData | input | 32 | Register port write data |
| regRdData | output | 32 | Register port read data for `regAddr` |

## Verification
Assertions check every cycle that the restart address follows the correct source for each precise and delay-slot combination. They also check that the flags stay one-hot or clear, that flags clear inside debug mode, and that a capture wins over a same-cycle write. The bench covers the behaviour that only shows up through the register port. It sweeps every combination of the qualifiers, cause strobe, debug-mode state and write collision. In that sweep it shows how the branch-delay indicator holds across imprecise captures, how the status word is laid out, and that writes to the status address have no effect.

// File: rtl/dbg_epc_pkg.sv
package dbg_epc_pkg;

  localparam int NUM_CAUSES = 4;
  localparam int BD_BIT     = 31;
  localparam logic ADDR_PC     = 1'b0;
  localparam logic ADDR_STATUS = 1'b1;

  typedef enum logic [1:0] {
    SRC_FAULT  = 2'd0,
    SRC_BRANCH = 2'd1,
    SRC_RESUME = 2'd2,
    SRC_SW     = 2'd3
  } pcSrc_e;

  typedef struct packed {
    logic                  loadPc;
    pcSrc_e                pcSrc;
    logic                  loadBd;
    logic                  bdValue;
    logic                  loadCause;
    logic [NUM_CAUSES-1:0] causeNext;
  } ctrlStrobe_t;

endpackage

// File: rtl/dbg_epc_ctrl.sv
module dbg_epc_ctrl
  import dbg_epc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  excValid,
  input  logic                  inDebugMode,
  input  logic                  excPrecise,
  input  logic                  inDelaySlot,
  input  logic [NUM_CAUSES-1:0] causeStrobe,
  input  logic                  regWrEn,
  input  logic                  regAddr,
  output ctrlStrobe_t           strobe
);

  logic swPcWrite;

  assign swPcWrite = regWrEn && (regAddr == ADDR_PC);

  always_comb begin
    strobe           = '0;
    strobe.pcSrc     = SRC_SW;
    strobe.causeNext = '0;
    if (excValid) begin
      // Hardware capture takes priority over the register port.
      strobe.loadPc = 1'b1;
      if (!excPrecise) begin
        strobe.pcSrc  = SRC_RESUME;
        strobe.loadBd = 1'b0;
      end else if (inDelaySlot) begin
        strobe.pcSrc   = SRC_BRANCH;
        strobe.loadBd  = 1'b1;
        strobe.bdValue = 1'b1;
      end else begin
        strobe.pcSrc   = SRC_FAULT;
        strobe.loadBd  = 1'b1;
        strobe.bdValue = 1'b0;
      end
      strobe.loadCause = 1'b1;
      strobe.causeNext = inDebugMode ? '0 : causeStrobe;
    end else if (swPcWrite) begin
      strobe.loadPc = 1'b1;
      strobe.pcSrc  = SRC_SW;
    end
  end

  // The core must present exactly one cause on an exception taken outside debug mode.
  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    (excValid && !inDebugMode) |-> $onehot(causeStrobe)) else $error("cause strobe not one-hot"); // R6

endmodule

// File: rtl/dbg_epc_dpath.sv
module dbg_epc_dpath
  import dbg_epc_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobe_t           strobe,
  input  logic [PC_W-1:0]       faultPc,
  input  logic [PC_W-1:0]       branchPc,
  input  logic [PC_W-1:0]       resumePc,
  input  logic [PC_W-1:0]       swData,
  output logic [PC_W-1:0]       epcQ,
  output logic                  bdQ,
  output logic [NUM_CAUSES-1:0] causeQ
);

  logic [PC_W-1:0] pcNext;

  always_comb begin
    unique case (strobe.pcSrc)
      SRC_FAULT:  pcNext = faultPc;
      SRC_BRANCH: pcNext = branchPc;
      SRC_RESUME: pcNext = resumePc;
      default:    pcNext = swData;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      epcQ   <= '0;
      bdQ    <= 1'b0;
      causeQ <= '0;
    end else begin
      if (strobe.loadPc)    epcQ   <= pcNext;
      if (strobe.loadBd)    bdQ    <= strobe.bdValue;
      if (strobe.loadCause) causeQ <= strobe.causeNext;
    end
  end

  AST_CAUSE_ONEHOT0: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(causeQ)) else $error("cause flags not one-hot"); // R6

endmodule

// File: rtl/dbg_epc_capture.sv
module dbg_epc_capture
  import dbg_epc_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  excValid,
  input  logic                  inDebugMode,
  input  logic                  excPrecise,
  input  logic                  inDelaySlot,
  input  logic [PC_W-1:0]       faultPc,
  input  logic [PC_W-1:0]       branchPc,
  input  logic [PC_W-1:0]       resumePc,
  input  logic [NUM_CAUSES-1:0] causeStrobe,
  input  logic                  regWrEn,
  input  logic                  regAddr,
  input  logic [PC_W-1:0]       regWrData,
  output logic [PC_W-1:0]       regRdData
);

  localparam int PAD_W = PC_W - NUM_CAUSES - 1;

  ctrlStrobe_t           strobe;
  logic [PC_W-1:0]       epcQ;
  logic                  bdQ;
  logic [NUM_CAUSES-1:0] causeQ;
  logic [PC_W-1:0]       statusWord;

  dbg_epc_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .excValid    (excValid),
    .inDebugMode (inDebugMode),
    .excPrecise  (excPrecise),
    .inDelaySlot (inDelaySlot),
    .causeStrobe (causeStrobe),
    .regWrEn     (regWrEn),
    .regAddr     (regAddr),
    .strobe      (strobe)
  );

  dbg_epc_dpath #(.PC_W(PC_W)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .faultPc  (faultPc),
    .branchPc (branchPc),
    .resumePc (resumePc),
    .swData   (regWrData),
    .epcQ     (epcQ),
    .bdQ      (bdQ),
    .causeQ   (causeQ)
  );

  assign statusWord = {bdQ, {PAD_W{1'b0}}, causeQ};
  assign regRdData  = (regAddr == ADDR_STATUS) ? statusWord : epcQ;

  AST_PRECISE_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    (excValid && excPrecise && !inDelaySlot) |=> (epcQ == $past(faultPc) && !bdQ)) else $error("fault pc capture"); // R3
  AST_PRECISE_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    (excValid && excPrecise && inDelaySlot) |=> (epcQ == $past(branchPc) && bdQ)) else $error("branch pc capture"); // R4
  AST_IMPRECISE: assert property (@(posedge clk) disable iff (!rstN)
    (excValid && !excPrecise) |=> (epcQ == $past(resumePc) && $stable(bdQ))) else $error("resume pc capture"); // R5
  AST_DEBUG_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (excValid && inDebugMode) |=> (causeQ == '0)) else $error("flags not cleared"); // R7
  AST_SW_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (!excValid && regWrEn && regAddr == ADDR_PC) |=> (epcQ == $past(regWrData))) else $error("sw write lost"); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!excValid && !(regWrEn && regAddr == ADDR_PC)) |=> ($stable(epcQ) && $stable(causeQ) && $stable(bdQ))) else $error("state moved"); // R8

endmodule

// File: tb/dbg_epc_capture_bench.sv
module dbg_epc_capture_bench;

  logic        clk = 1'b0;
  logic        rstN;
  logic        excValid, inDebugMode, excPrecise, inDelaySlot;
  logic [31:0] faultPc, branchPc, resumePc, regWrData, regRdData;
  logic [3:0]  causeStrobe;
  logic        regWrEn, regAddr;

  int checks = 0;
  int errors = 0;
  logic [31:0] epcE;
  logic        bdE;
  logic [3:0]  causeE;

  always #5 clk = ~clk;

  dbg_epc_capture u_dbg_epc_capture (
    .clk(clk), .rstN(rstN), .excValid(excValid), .inDebugMode(inDebugMode),
    .excPrecise(excPrecise), .inDelaySlot(inDelaySlot), .faultPc(faultPc),
    .branchPc(branchPc), .resumePc(resumePc), .causeStrobe(causeStrobe),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    excValid = 0; regWrEn = 0; causeStrobe = 0;
  endtask

  // Called just after a negedge: read both addresses and compare with the model.
  task automatic readBoth(input string req);
    regAddr = 1'b0; #1;
    check({req, " pc"}, regRdData, epcE);
    regAddr = 1'b1; #1;
    check({req, " status(R10)"}, regRdData, {bdE, 27'd0, causeE});
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rstN = 0; idle(); inDebugMode = 0; excPrecise = 0; inDelaySlot = 0;
    faultPc = 0; branchPc = 0; resumePc = 0; regWrData = 0; regAddr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1;
    epcE = 0; bdE = 0; causeE = 0;
    readBoth("R1 reset");

    // R2: walking-one and pattern writes to the pc register
    for (int b = 0; b < 34; b++) begin
      @(negedge clk);
      regWrEn = 1; regAddr = 0;
      regWrData = (b < 32) ? (32'h1 << b) : (b == 32 ? 32'hFFFF_FFFF : 32'hA5C3_3C5A);
      epcE = regWrData;
      @(negedge clk); idle();
      regAddr = 0; #1;
      check("R2 sw write", regRdData, epcE);
    end

    // Sweep qualifiers, debug state, cause index and write collision
    for (int i = 0; i < 64; i++) begin
      logic prec, dly, dbg, coll;
      int sidx;
      prec = i[0]; dly = i[1]; dbg = i[2]; sidx = (i >> 3) & 3; coll = i[5];
      @(negedge clk);
      faultPc  = 32'h8000_0000 + i * 16;
      branchPc = faultPc - 32'd4;
      resumePc = 32'h4000_0000 ^ (i * 32'h0101_0010);
      excValid = 1; excPrecise = prec; inDelaySlot = dly; inDebugMode = dbg;
      causeStrobe = 4'b1 << sidx;
      regWrEn = coll; regAddr = 0; regWrData = 32'hDEAD_0000 | i;
      if (!prec) epcE = resumePc;
      else if (dly) begin epcE = branchPc; bdE = 1; end
      else begin epcE = faultPc; bdE = 0; end
      causeE = dbg ? 4'b0 : (4'b1 << sidx);
      @(negedge clk); idle();
      if (coll) readBoth("R9 capture wins");
      else if (!prec) readBoth("R5 imprecise");
      else if (dly) readBoth("R4 delay slot");
      else readBoth("R3 precise");
      regAddr = 1; #1;
      if (dbg) check("R7 debug clear", {28'd0, regRdData[3:0]}, 32'd0);
      else check("R6 cause flag", {28'd0, regRdData[3:0]}, {28'd0, 4'b1 << sidx});
    end

    // R8: writes to the status address are ignored
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      regWrEn = 1; regAddr = 1; regWrData = (k[0] ? 32'hFFFF_FFFF : 32'h0) ^ (k * 32'h1111_0000);
      @(negedge clk); idle();
      readBoth("R8 status write");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule